// File: doc/BRIEF.md
# DMA Channel Register Bank with Interrupt Capture

This block is the software-visible register bank of a four-channel DMA controller. A 32-bit word-addressed access port reaches a small global region (a read-as-zero control word, two interrupt mask words and two interrupt source words) and one eight-word window per channel. Each window holds the channel's control/status word and its configuration: transfer size, source and destination address, source and destination address masks, descriptor pointer and a software scratch pointer. The configuration values are driven out to the channel engines, which live outside this block.

The channel engines report chunk completion, transfer completion and error through single-cycle strobes. The bank turns each strobe into sticky status bits. When the channel has enabled that interrupt and its bit in mask A is set, the bank also records the channel in interrupt source A and raises the interrupt line. Software clears the error and interrupt status of a channel by reading its control/status word. Writes to that word change only the configuration bits.

Every access is answered exactly one cycle later with `rsp_valid`. The response carries the read data, or an error flag for an illegal offset.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, both address-mask words of every channel read 0xFFFFFFFC, every other register reads 0, and `irq` is low.
- R2: Each access presented with `req_valid` is answered in the following cycle by `rsp_valid` high for one cycle. A read returns the register value held at the time of the request, and a write returns data 0.
- R3: An access is illegal when its offset is not a multiple of 4, when it falls in the global region at 0x14, 0x18 or 0x1C, or when it lies at or above 0xA0. An illegal access answers with `rsp_err` high and data 0, and changes no register.
- R4: Channel k occupies offsets 0x20+0x20*k to 0x3F+0x20*k. Within the window, word 0 is the control/status word, word 1 the size, word 2 the source address, word 3 the source mask, word 4 the destination address, word 5 the destination mask, word 6 the descriptor pointer and word 7 the software pointer. Words 1 to 7 store all 32 bits written.
- R5: Reading a control/status word returns its value and then clears bit 13 (error), bit 14 (error interrupt), bit 15 (done interrupt) and bit 16 (chunk interrupt).
- R6: A write to a control/status word replaces bits 10:0 only. Bits 10:0 are: 0 enable, 1 request-paced, 2 source increment, 3 destination increment, 4 descriptor mode, 5 auto-restart, 6 stop, 7 size write-back, 8 error-interrupt enable, 9 done-interrupt enable, 10 chunk-interrupt enable. All status bits keep their value.
- R7: A done strobe sets bit 12 and clears the enable bit. An error strobe sets bit 13 and clears the enable bit. A write that sets the enable bit while it is clear also clears bit 12.
- R8: A done, error or chunk strobe sets bit 15, 14 or 16 respectively only when the matching enable (bit 9, 8 or 10) and the channel's bit in mask A are both set. Otherwise the interrupt bit and source A stay unchanged.
- R9: When any channel raises an interrupt, source A is overwritten with the one-hot bit of the highest-numbered raising channel. This capture takes precedence over a software write to source A in the same cycle.
- R10: `irq` is high exactly when (source A AND mask A) or (source B AND mask B) is nonzero.
- R11: The global control word at offset 0x00 always reads 0, and writes to it have no effect.
- R12: When a status-setting strobe and a read of the same control/status word fall in the same cycle, the read returns the old value and the newly set bits remain set afterwards.
- R13: The mask and source words at 0x04 (mask A), 0x08 (mask B), 0x0C (source A) and 0x10 (source B) hold one bit per channel in bits 3:0, and their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Previous access was illegal |
| ev_chunk | input | 4 | Per-channel chunk-complete strobe |
| ev_done | input | 4 | Per-channel transfer-done strobe |
| ev_err | input | 4 | Per-channel error strobe |
| ch_csr_o | output | 128 | Control/status words, channel k at bits 32k+31:32k |
| ch_size_o | output | 128 | Size words |
| ch_src_o | output | 128 | Source addresses |
| ch_src_mask_o | output | 128 | Source address masks |
| ch_dst_o | output | 128 | Destination addresses |
| ch_dst_mask_o | output | 128 | Destination address masks |
| ch_desc_o | output | 128 | Descriptor pointers |
| irq | output | 1 | Interrupt request |

## Verification
A read's data, any error flag and `rsp_valid` appear at the first clock edge after the request. Register side effects (read-clear, masked write, strobe capture) take effect at that same edge. `irq` is a combinational function of the registers, so it reflects an update one edge after the stimulus. The bench drives every request and strobe for one cycle from a falling edge. It samples the response, its model and `irq` at the next falling edge, exactly one edge later. The model is updated only after that comparison, in the order read-clear, write, then strobes, with interrupt enables and masks taken from before the access.

// File: rtl/dmac_regbank_pkg.sv
package dmac_regbank_pkg;

  localparam int unsigned DW = 32;

  // control/status bit positions
  localparam int B_EN        = 0;
  localparam int B_IE_ERR    = 8;
  localparam int B_IE_DONE   = 9;
  localparam int B_IE_CHUNK  = 10;
  localparam int B_DONE      = 12;
  localparam int B_ERR       = 13;
  localparam int B_INT_ERR   = 14;
  localparam int B_INT_DONE  = 15;
  localparam int B_INT_CHUNK = 16;

  localparam logic [DW-1:0] CSR_WR_MASK = 32'h0000_07FF;
  localparam logic [DW-1:0] CSR_RC_MASK = 32'h0001_E000;
  localparam logic [DW-1:0] AMASK_RESET = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    CR_CTL, CR_SIZE, CR_SRC, CR_SRCM, CR_DST, CR_DSTM, CR_DESC, CR_SWPTR
  } chreg_e;

  typedef enum logic [2:0] {
    GR_CTL, GR_MSKA, GR_MSKB, GR_SRCA, GR_SRCB, GR_NONE
  } greg_e;

  // software write into a control/status word
  function automatic logic [DW-1:0] csr_merge(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] wd);
    logic [DW-1:0] r;
    r = (cur & ~CSR_WR_MASK) | (wd & CSR_WR_MASK);
    if (wd[B_EN] && !cur[B_EN]) r[B_DONE] = 1'b0;
    return r;
  endfunction

  // interrupt raises {chunk, done, err} of one channel
  function automatic logic [2:0] int_hits(input logic [DW-1:0] cur,
                                          input logic chunk,
                                          input logic done,
                                          input logic err,
                                          input logic msk);
    return {chunk & cur[B_IE_CHUNK], done & cur[B_IE_DONE], err & cur[B_IE_ERR]}
           & {3{msk}};
  endfunction

endpackage

// File: rtl/dmac_addr_decode.sv
module dmac_addr_decode
  import dmac_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH = 4,
  parameter logic [ADDR_W-1:0] CH_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CH_STRIDE = 8'h20,
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bad,
  output logic              hit_ch,
  output greg_e             glob_sel,
  output logic [CIW-1:0]    ch_idx,
  output chreg_e            ch_reg
);

  logic [ADDR_W-1:0] rel, num, off;

  assign rel = addr - CH_BASE;
  assign num = rel / CH_STRIDE;
  assign off = rel % CH_STRIDE;

  always_comb begin
    bad      = 1'b0;
    hit_ch   = 1'b0;
    glob_sel = GR_NONE;
    ch_idx   = '0;
    ch_reg   = CR_CTL;
    if (addr[1:0] != 2'b00) begin
      bad = 1'b1;
    end else if (addr < CH_BASE) begin
      if      (addr == ADDR_W'(0))  glob_sel = GR_CTL;
      else if (addr == ADDR_W'(4))  glob_sel = GR_MSKA;
      else if (addr == ADDR_W'(8))  glob_sel = GR_MSKB;
      else if (addr == ADDR_W'(12)) glob_sel = GR_SRCA;
      else if (addr == ADDR_W'(16)) glob_sel = GR_SRCB;
      else                          bad = 1'b1;
    end else if (num >= ADDR_W'(NCH) || off >= ADDR_W'(32)) begin
      bad = 1'b1;
    end else begin
      hit_ch = 1'b1;
      ch_idx = num[CIW-1:0];
      ch_reg = chreg_e'(off[4:2]);
    end
  end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          csr_rd_stb,
  input  chreg_e        sel,
  input  logic [DW-1:0] wdata,
  input  logic          ev_chunk,
  input  logic          ev_done,
  input  logic          ev_err,
  input  logic          msk_a_bit,
  output logic [DW-1:0] csr_q,
  output logic [DW-1:0] size_q,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] srcm_q,
  output logic [DW-1:0] dst_q,
  output logic [DW-1:0] dstm_q,
  output logic [DW-1:0] desc_q,
  output logic [DW-1:0] rd_val,
  output logic          raise
);

  logic [DW-1:0] swptr_q;
  logic [DW-1:0] csr_d;
  logic [2:0]    hits;

  assign hits  = int_hits(csr_q, ev_chunk, ev_done, ev_err, msk_a_bit);
  assign raise = |hits;

  always_comb begin
    csr_d = csr_q;
    if (csr_rd_stb) csr_d = csr_d & ~CSR_RC_MASK;
    if (wr_stb && sel == CR_CTL) csr_d = csr_merge(csr_q, wdata);
    if (ev_done) begin
      csr_d[B_DONE] = 1'b1;
      csr_d[B_EN]   = 1'b0;
    end
    if (ev_err) begin
      csr_d[B_ERR] = 1'b1;
      csr_d[B_EN]  = 1'b0;
    end
    if (hits[2]) csr_d[B_INT_CHUNK] = 1'b1;
    if (hits[1]) csr_d[B_INT_DONE]  = 1'b1;
    if (hits[0]) csr_d[B_INT_ERR]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q   <= '0;
      size_q  <= '0;
      src_q   <= '0;
      srcm_q  <= AMASK_RESET;
      dst_q   <= '0;
      dstm_q  <= AMASK_RESET;
      desc_q  <= '0;
      swptr_q <= '0;
    end else begin
      csr_q <= csr_d;
      if (wr_stb) begin
        case (sel)
          CR_SIZE:  size_q  <= wdata;
          CR_SRC:   src_q   <= wdata;
          CR_SRCM:  srcm_q  <= wdata;
          CR_DST:   dst_q   <= wdata;
          CR_DSTM:  dstm_q  <= wdata;
          CR_DESC:  desc_q  <= wdata;
          CR_SWPTR: swptr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      CR_CTL:   rd_val = csr_q;
      CR_SIZE:  rd_val = size_q;
      CR_SRC:   rd_val = src_q;
      CR_SRCM:  rd_val = srcm_q;
      CR_DST:   rd_val = dst_q;
      CR_DSTM:  rd_val = dstm_q;
      CR_DESC:  rd_val = desc_q;
      default:  rd_val = swptr_q;
    endcase
  end

endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl
  import dmac_regbank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  greg_e          sel,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] raise,
  output logic [NCH-1:0] msk_a,
  output logic [NCH-1:0] msk_b,
  output logic [NCH-1:0] src_a,
  output logic [NCH-1:0] src_b,
  output logic           irq
);

  // one-hot of the highest set bit
  function automatic logic [NCH-1:0] top_onehot(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    r = '0;
    for (int i = 0; i < NCH; i++) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_a <= '0;
      msk_b <= '0;
      src_a <= '0;
      src_b <= '0;
    end else begin
      if (wr_stb && sel == GR_MSKA) msk_a <= wdata[NCH-1:0];
      if (wr_stb && sel == GR_MSKB) msk_b <= wdata[NCH-1:0];
      if (wr_stb && sel == GR_SRCB) src_b <= wdata[NCH-1:0];
      if (|raise)                           src_a <= top_onehot(raise);
      else if (wr_stb && sel == GR_SRCA)    src_a <= wdata[NCH-1:0];
    end
  end

  assign irq = (|(src_a & msk_a)) | (|(src_b & msk_b));

endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_regbank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CH_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CH_STRIDE = 8'h20,
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [NCH-1:0]    ev_chunk,
  input  logic [NCH-1:0]    ev_done,
  input  logic [NCH-1:0]    ev_err,
  output logic [NCH*32-1:0] ch_csr_o,
  output logic [NCH*32-1:0] ch_size_o,
  output logic [NCH*32-1:0] ch_src_o,
  output logic [NCH*32-1:0] ch_src_mask_o,
  output logic [NCH*32-1:0] ch_dst_o,
  output logic [NCH*32-1:0] ch_dst_mask_o,
  output logic [NCH*32-1:0] ch_desc_o,
  output logic              irq
);

  logic           bad, hit_ch, acc_rd, acc_wr;
  greg_e          glob_sel;
  logic [CIW-1:0] ch_idx;
  chreg_e         ch_reg;
  logic [NCH-1:0] msk_a_q, msk_b_q, src_a_q, src_b_q;
  logic [NCH-1:0] raise_vec, csr_rd_vec, ch_wr_vec;
  logic [DW-1:0]  ch_rd [NCH];
  logic [DW-1:0]  glob_rd, rd_mux;

  dmac_addr_decode #(
    .ADDR_W(ADDR_W), .NCH(NCH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_dec (
    .addr(req_addr), .bad(bad), .hit_ch(hit_ch), .glob_sel(glob_sel),
    .ch_idx(ch_idx), .ch_reg(ch_reg)
  );

  assign acc_rd = req_valid & ~req_write & ~bad;
  assign acc_wr = req_valid &  req_write & ~bad;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_wr_vec[k]  = acc_wr & hit_ch & (ch_idx == CIW'(k));
    assign csr_rd_vec[k] = acc_rd & hit_ch & (ch_idx == CIW'(k)) & (ch_reg == CR_CTL);

    dmac_chan_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(ch_wr_vec[k]), .csr_rd_stb(csr_rd_vec[k]),
      .sel(ch_reg), .wdata(req_wdata),
      .ev_chunk(ev_chunk[k]), .ev_done(ev_done[k]), .ev_err(ev_err[k]),
      .msk_a_bit(msk_a_q[k]),
      .csr_q(ch_csr_o[k*32 +: 32]), .size_q(ch_size_o[k*32 +: 32]),
      .src_q(ch_src_o[k*32 +: 32]), .srcm_q(ch_src_mask_o[k*32 +: 32]),
      .dst_q(ch_dst_o[k*32 +: 32]), .dstm_q(ch_dst_mask_o[k*32 +: 32]),
      .desc_q(ch_desc_o[k*32 +: 32]),
      .rd_val(ch_rd[k]), .raise(raise_vec[k])
    );
  end

  dmac_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(acc_wr & ~hit_ch), .sel(glob_sel), .wdata(req_wdata),
    .raise(raise_vec),
    .msk_a(msk_a_q), .msk_b(msk_b_q), .src_a(src_a_q), .src_b(src_b_q),
    .irq(irq)
  );

  always_comb begin
    case (glob_sel)
      GR_MSKA: glob_rd = DW'(msk_a_q);
      GR_MSKB: glob_rd = DW'(msk_b_q);
      GR_SRCA: glob_rd = DW'(src_a_q);
      GR_SRCB: glob_rd = DW'(src_b_q);
      default: glob_rd = '0;
    endcase
  end

  assign rd_mux = hit_ch ? ch_rd[ch_idx] : glob_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & bad;
      rsp_rdata <= acc_rd ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk #(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              irq,
  input logic [NCH-1:0]    ev_chunk,
  input logic [NCH-1:0]    ev_done,
  input logic [NCH-1:0]    ev_err,
  input logic [NCH*32-1:0] ch_csr_o,
  input logic [NCH-1:0]    src_a_q,
  input logic [NCH-1:0]    raise_vec,
  input logic [NCH-1:0]    csr_rd_vec
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0));

  // R9
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_vec) |=> ($countones(src_a_q) == 1));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|raise_vec) || (req_valid && req_write)));

  for (genvar k = 0; k < NCH; k++) begin : g_ck
    // R7
    stop_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done[k] || ev_err[k]) |=> !ch_csr_o[k*32]);

    // R5
    rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_vec[k] && !ev_chunk[k] && !ev_done[k] && !ev_err[k])
        |=> (ch_csr_o[k*32+13 +: 4] == 4'h0));

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd_vec[k] && ev_err[k]) |=> ch_csr_o[k*32+13]);
  end

endmodule

bind dmac_regbank dmac_regbank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq),
  .ev_chunk(ev_chunk), .ev_done(ev_done), .ev_err(ev_err),
  .ch_csr_o(ch_csr_o), .src_a_q(src_a_q), .raise_vec(raise_vec),
  .csr_rd_vec(csr_rd_vec)
);

// File: tb/test_dmac_regbank.sv
module test_dmac_regbank;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid, rsp_err, irq;
  logic [31:0]  rsp_rdata;
  logic [3:0]   ev_chunk = '0, ev_done = '0, ev_err = '0;
  logic [127:0] o_csr, o_size, o_src, o_srcm, o_dst, o_dstm, o_desc;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_ch [4][8];
  logic [3:0]  m_mska, m_mskb, m_srca, m_srcb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_regbank i_dmac_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ev_chunk(ev_chunk),
    .ev_done(ev_done), .ev_err(ev_err), .ch_csr_o(o_csr), .ch_size_o(o_size),
    .ch_src_o(o_src), .ch_src_mask_o(o_srcm), .ch_dst_o(o_dst),
    .ch_dst_mask_o(o_dstm), .ch_desc_o(o_desc), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench view of the address map: ch = -1 for global, idx = word index
  task automatic m_decode(input logic [7:0] a, output logic bad, output int ch, output int idx);
    bad = 1'b0; ch = -1; idx = 0;
    if (a % 4 != 0) bad = 1'b1;
    else if (a < 8'h20) begin
      idx = int'(a) / 4;
      if (idx > 4) bad = 1'b1;
    end else begin
      ch  = (int'(a) - 32) / 32;
      idx = ((int'(a) - 32) % 32) / 4;
      if (ch > 3) bad = 1'b1;
    end
  endtask

  function automatic logic [31:0] m_get(input int ch, input int idx);
    if (ch >= 0) return m_ch[ch][idx];
    case (idx)
      1: return {28'h0, m_mska};
      2: return {28'h0, m_mskb};
      3: return {28'h0, m_srca};
      4: return {28'h0, m_srcb};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_csr_wr(input logic [31:0] cur, input logic [31:0] d);
    logic [31:0] r;
    r = {cur[31:11], d[10:0]};
    if (!cur[0] && d[0]) r[12] = 1'b0;
    return r;
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 8; i++)
        m_ch[c][i] = (i == 3 || i == 5) ? 32'hFFFF_FFFC : 32'h0;
    m_mska = '0; m_mskb = '0; m_srca = '0; m_srcb = '0;
  endtask

  // one cycle: optional access plus strobes, then compare and update model
  task automatic op(input logic v, input logic wr, input logic [7:0] a,
                    input logic [31:0] d, input logic [3:0] evc,
                    input logic [3:0] evd, input logic [3:0] eve, input string tag);
    logic        bad;
    int          ch, idx;
    logic [31:0] exp;
    logic [31:0] old_csr [4];
    logic [3:0]  old_mska, raise;
    m_decode(a, bad, ch, idx);
    exp = (v && !wr && !bad) ? m_get(ch, idx) : 32'h0;
    for (int c = 0; c < 4; c++) old_csr[c] = m_ch[c][0];
    old_mska = m_mska;
    @(negedge clk);
    req_valid = v; req_write = wr; req_addr = a; req_wdata = d;
    ev_chunk = evc; ev_done = evd; ev_err = eve;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ev_chunk = '0; ev_done = '0; ev_err = '0;
    chk({tag, " R2 rsp_valid"}, 32'(rsp_valid), 32'(v));
    if (v) begin
      chk({tag, " R3 rsp_err"}, 32'(rsp_err), 32'(bad));
      chk({tag, " R2 rdata"}, rsp_rdata, exp);
    end
    if (v && !bad) begin
      if (wr) begin
        if (ch >= 0) m_ch[ch][idx] = (idx == 0) ? m_csr_wr(m_ch[ch][0], d) : d;
        else if (idx == 1) m_mska = d[3:0];
        else if (idx == 2) m_mskb = d[3:0];
        else if (idx == 3) m_srca = d[3:0];
        else if (idx == 4) m_srcb = d[3:0];
      end else if (ch >= 0 && idx == 0) begin
        m_ch[ch][0] = m_ch[ch][0] & ~32'h0001_E000;
      end
    end
    raise = '0;
    for (int c = 0; c < 4; c++) begin
      if (evd[c]) begin m_ch[c][0][12] = 1'b1; m_ch[c][0][0] = 1'b0; end
      if (eve[c]) begin m_ch[c][0][13] = 1'b1; m_ch[c][0][0] = 1'b0; end
      if (old_mska[c]) begin
        if (evc[c] && old_csr[c][10]) begin m_ch[c][0][16] = 1'b1; raise[c] = 1'b1; end
        if (evd[c] && old_csr[c][9])  begin m_ch[c][0][15] = 1'b1; raise[c] = 1'b1; end
        if (eve[c] && old_csr[c][8])  begin m_ch[c][0][14] = 1'b1; raise[c] = 1'b1; end
      end
    end
    for (int c = 0; c < 4; c++) if (raise[c]) m_srca = 4'(1 << c);
    chk({tag, " R10 irq"}, 32'(irq), 32'(((m_srca & m_mska) != 0) || ((m_srcb & m_mskb) != 0)));
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    op(1'b1, 1'b0, a, 32'h0, 4'h0, 4'h0, 4'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    op(1'b1, 1'b1, a, d, 4'h0, 4'h0, 4'h0, tag);
  endtask

  task automatic ev(input logic [3:0] c, input logic [3:0] dn, input logic [3:0] e, input string tag);
    op(1'b0, 1'b0, 8'h0, 32'h0, c, dn, e, tag);
  endtask

  function automatic logic [7:0] ch_addr(input int c, input int i);
    return 8'(32 + 32 * c + 4 * i);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    m_reset();
    repeat (3) @(negedge clk);
    chk("R1 irq at reset", 32'(irq), 32'h0);
    chk("R2 rsp_valid at reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;

    // R1 reset values everywhere
    for (int g = 0; g < 5; g++) rd(8'(4 * g), "R1 global");
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 8; i++) rd(ch_addr(c, i), "R1 channel");

    // R11 global control ignores writes
    wr(8'h00, 32'hFFFF_FFFF, "R11 write");
    rd(8'h00, "R11 read");

    // R13 mask widths
    wr(8'h04, 32'hFFFF_FFFF, "R13 mska");
    rd(8'h04, "R13 mska");
    wr(8'h08, 32'hA5A5_A5A5, "R13 mskb");
    rd(8'h08, "R13 mskb");

    // R3 illegal accesses
    rd(8'h06, "R3 misaligned");
    rd(8'h14, "R3 hole");
    wr(8'h1C, 32'h0000_000F, "R3 hole write");
    wr(8'hA0, 32'h1234_5678, "R3 beyond");
    wr(8'h21, 32'hFFFF_FFFF, "R3 misaligned write");
    rd(8'h04, "R3 mska intact");
    rd(ch_addr(0, 0), "R3 csr intact");

    // R4 window layout
    for (int c = 0; c < 4; c++)
      for (int i = 1; i < 8; i++) wr(ch_addr(c, i), 32'h0100_0000 * (c + 1) + 32'(i * 17), "R4 write");
    for (int c = 0; c < 4; c++)
      for (int i = 1; i < 8; i++) rd(ch_addr(c, i), "R4 read");
    chk("R4 size out ch3", o_size[127:96], m_ch[3][1]);
    chk("R4 dst mask out ch1", o_dstm[63:32], m_ch[1][5]);

    // R6 masked write, R5 read clear, R8 error interrupt
    wr(ch_addr(2, 0), 32'hFFFF_FFFF, "R6 write");
    rd(ch_addr(2, 0), "R6 read");
    ev(4'h0, 4'h0, 4'h4, "R8 err event");
    wr(ch_addr(2, 0), 32'h0, "R6 preserve");
    rd(ch_addr(2, 0), "R5 first read");
    rd(ch_addr(2, 0), "R5 cleared");
    rd(8'h0C, "R9 srca");

    // R7 done and enable
    wr(ch_addr(0, 0), 32'h0000_0001, "R7 enable");
    ev(4'h0, 4'h1, 4'h0, "R7 done");
    rd(ch_addr(0, 0), "R7 done set");
    wr(ch_addr(0, 0), 32'h0000_0001, "R7 re-enable");
    rd(ch_addr(0, 0), "R7 done cleared");

    // R12 read and set in same cycle
    wr(ch_addr(1, 0), 32'h0000_0101, "R12 setup");
    op(1'b1, 1'b0, ch_addr(1, 0), 32'h0, 4'h0, 4'h0, 4'h2, "R12 read+err");
    rd(ch_addr(1, 0), "R12 set wins");

    // R9 priority and capture over software write
    wr(ch_addr(1, 0), 32'h0000_0200, "R9 ie ch1");
    wr(ch_addr(3, 0), 32'h0000_0200, "R9 ie ch3");
    ev(4'h0, 4'hA, 4'h0, "R9 two done");
    rd(8'h0C, "R9 highest wins");
    wr(ch_addr(0, 0), 32'h0000_0400, "R9 ie chunk");
    op(1'b1, 1'b1, 8'h0C, 32'h0000_0002, 4'h1, 4'h0, 4'h0, "R9 capture beats write");
    rd(8'h0C, "R9 capture");

    // R8 masked off: no interrupt
    wr(8'h04, 32'h0, "R8 mask off");
    ev(4'h0, 4'h2, 4'h0, "R8 no raise");
    rd(ch_addr(1, 0), "R8 status only");
    rd(8'h0C, "R8 srca unchanged");

    // R10 source B path
    wr(8'h10, 32'h4, "R10 srcb");
    wr(8'h08, 32'h4, "R10 mskb on");
    wr(8'h08, 32'h0, "R10 mskb off");
    wr(8'h0C, 32'h0, "R10 clear srca");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int          k;
      logic [7:0]  a;
      logic        w;
      k = int'($urandom % 10);
      if (k == 0)      a = 8'($urandom);
      else if (k < 3)  a = 8'(4 * ($urandom % 5));
      else             a = ch_addr(int'($urandom % 4), int'($urandom % 8));
      w = ($urandom % 2) == 0;
      op(($urandom % 8) != 0, w, a, $urandom,
         4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom) & 4'($urandom),
         4'($urandom) & 4'($urandom) & 4'($urandom), "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule